// File: doc/BRIEF.md
# Descriptor-Chaining Bus DMA Controller

This block is a DMA engine that copies 32-bit words between a local memory bus and a second system bus. The processor sets it up through a small register window. In direct mode, software loads a local address, a system-bus address, a byte count and a working command word, then sets the go bit. In chaining mode, software loads a table address instead. The engine then fetches five-word command descriptors from local memory and runs them one after another until it reaches a descriptor flagged as the last one.

Each word takes one read beat on the source bus and one write beat on the destination bus. Both buses use a plain request/acknowledge handshake with an error response. The working command word is shared between the two modes: software loads it in direct mode, and the engine reloads it from every descriptor in chaining mode.

An on/off throttle limits how many cycles the engine may request the system bus before it has to stay off that bus for a set time. When the engine stops, it records the cause in sticky status bits and pulses the interrupt request. A descriptor can also request its own interrupt pulse when it finishes.

Top module: `chain_dma`

## Requirements
- R1: After reset every readable register reads 0, no bus request is raised and irq_o is low.
- R2: In direct mode with command bit 0 set, the engine copies count/4 words from local to system memory, each word going to the matching offset. Both addresses advance by 4 per word, and the count reads 0 at the end.
- R3: In direct mode with command bit 0 clear, the copy runs from system memory to local memory, with the same address and count behaviour as R2.
- R4: When the engine stops, the go bit (control bit 0) reads 0 again. Status busy (bit 4) is 1 while the engine runs and clears when it stops. irq_o pulses for exactly one cycle, and a normal finish sets status done (bit 0).
- R5: Status bits 0 to 3 are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: A count that is not a multiple of 4 stops the engine at once. It sets status bit 3 and raises no bus request.
- R7: An error response on the local bus sets status bit 1 and stops the engine. The local address, system address and count keep the values of the failing beat.
- R8: An error response on the system bus sets status bit 2 and stops the engine. The addresses and count are kept as in R7.
- R9: With control bit 1 set at go, the engine reads descriptors starting from the table address. Each descriptor has five words in this order: local address, system address, byte count, command word, next pointer. Descriptors run in list order, and bit 0 of the next pointer marks the last one.
- R10: A descriptor whose command bit 1 is set produces an irq_o pulse when it finishes, and the engine then moves on to the next descriptor.
- R11: The throttle word sets an on time in bits 15:0 and an off time in bits 31:16. After on-time cycles of system-bus request, no new system-bus request starts for at least off-time cycles. An on time of 0 disables the throttle.
- R12: Only one bus is requested at a time. A request and its address stay steady until an ack or an error arrives.
- R13: A direct command with count 0 finishes as done without any bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index: 0 control, 1 command, 2 local address, 3 system address, 4 count, 5 table, 6 status, 7 throttle |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| lb_req_o | output | 1 | Local bus request |
| lb_we_o | output | 1 | Local bus write (1) or read (0) |
| lb_addr_o | output | 32 | Local bus byte address |
| lb_wdata_o | output | 32 | Local bus write data |
| lb_rdata_i | input | 32 | Local bus read data, valid with ack |
| lb_ack_i | input | 1 | Local bus acknowledge |
| lb_err_i | input | 1 | Local bus error response |
| sb_req_o | output | 1 | System bus request |
| sb_we_o | output | 1 | System bus write (1) or read (0) |
| sb_addr_o | output | 32 | System bus byte address |
| sb_wdata_o | output | 32 | System bus write data |
| sb_rdata_i | input | 32 | System bus read data, valid with ack |
| sb_ack_i | input | 1 | System bus acknowledge |
| sb_err_i | input | 1 | System bus error response |
| irq_o | output | 1 | One-cycle interrupt request pulse |

## Verification
The assertions assume that each bus answers a pending request with a single one-cycle ack or error pulse and never responds when no request is pending. The count-step property also assumes software does not rewrite the working registers while a transfer is in flight.

The bench responders answer every request exactly one cycle after they see it. The ack drops in the following cycle, before any new request can be acknowledged. Errors are injected only at one chosen address. All register setup is done while status busy reads 0.

// File: rtl/chain_dma_pkg.sv
`timescale 1ns/1ps
package chain_dma_pkg;
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_RD, S_WR} eng_state_e;
  typedef enum logic [1:0] {STOP_DONE, STOP_LERR, STOP_SERR, STOP_FMT} stop_e;

  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_CMD    = 3'd1;
  localparam logic [2:0] REG_LADDR  = 3'd2;
  localparam logic [2:0] REG_SADDR  = 3'd3;
  localparam logic [2:0] REG_COUNT  = 3'd4;
  localparam logic [2:0] REG_TABLE  = 3'd5;
  localparam logic [2:0] REG_STATUS = 3'd6;
  localparam logic [2:0] REG_THR    = 3'd7;

  localparam int DESC_WORDS = 5;
endpackage

// File: rtl/chain_dma_throttle.sv
`timescale 1ns/1ps
module chain_dma_throttle #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] on_t_i,
  input  logic [TW-1:0] off_t_i,
  input  logic          active_i,
  output logic          allow_o
);
  logic          off_q;
  logic [TW-1:0] cnt_q;

  assign allow_o = !off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= 1'b0;
      cnt_q <= '0;
    end else if (!off_q) begin
      if (on_t_i == '0) begin
        cnt_q <= '0;
      end else if (active_i) begin
        if (cnt_q == on_t_i - TW'(1)) begin
          off_q <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + TW'(1);
        end
      end
    end else begin
      // off window lasts max(off_t,1) cycles
      if (off_t_i == '0 || cnt_q == off_t_i - TW'(1)) begin
        off_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + TW'(1);
      end
    end
  end
endmodule

// File: rtl/chain_dma_engine.sv
`timescale 1ns/1ps
module chain_dma_engine
  import chain_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          chain_i,
  input  logic [AW-1:0] table_i,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_sel_i,
  input  logic [DW-1:0] cfg_wdata_i,
  output logic [AW-1:0] laddr_o,
  output logic [AW-1:0] saddr_o,
  output logic [DW-1:0] count_o,
  output logic [1:0]    cmd_o,
  output logic          busy_o,
  output logic          stop_o,
  output stop_e         stop_cause_o,
  output logic          cmd_irq_o,
  output logic          lb_req_o,
  output logic          lb_we_o,
  output logic [AW-1:0] lb_addr_o,
  output logic [DW-1:0] lb_wdata_o,
  input  logic [DW-1:0] lb_rdata_i,
  input  logic          lb_ack_i,
  input  logic          lb_err_i,
  output logic          sb_req_o,
  output logic          sb_we_o,
  output logic [AW-1:0] sb_addr_o,
  output logic [DW-1:0] sb_wdata_o,
  input  logic [DW-1:0] sb_rdata_i,
  input  logic          sb_ack_i,
  input  logic          sb_err_i,
  input  logic          sb_allow_i
);
  localparam logic [AW-1:0] A_STEP  = AW'(4);
  localparam logic [DW-1:0] C_STEP  = DW'(4);
  localparam logic [AW-1:0] A_ALIGN = ~AW'(3);
  localparam int            WIW     = $clog2(DESC_WORDS);
  localparam logic [WIW-1:0] W_LAST = WIW'(DESC_WORDS - 1);

  eng_state_e     state_q;
  logic [AW-1:0]  laddr_q, saddr_q, ptr_q, next_q;
  logic [DW-1:0]  count_q, data_q;
  logic [1:0]     cmd_q;
  logic [WIW-1:0] widx_q;
  logic           chain_q, sb_hold_q;

  logic  src_local, lb_phase, sb_phase, bus_ack, bus_err;
  stop_e err_cause;

  assign src_local = cmd_q[0];
  assign lb_phase  = (state_q == S_FETCH) ||
                     (state_q == S_RD && src_local) ||
                     (state_q == S_WR && !src_local);
  assign sb_phase  = (state_q == S_RD && !src_local) ||
                     (state_q == S_WR && src_local);

  // a new system-bus beat waits for the throttle; a started one is held
  assign sb_req_o   = sb_phase && (sb_allow_i || sb_hold_q);
  assign lb_req_o   = lb_phase;
  assign lb_we_o    = (state_q == S_WR);
  assign sb_we_o    = (state_q == S_WR);
  assign lb_addr_o  = (state_q == S_FETCH) ? ptr_q + AW'({widx_q, 2'b00}) : laddr_q;
  assign sb_addr_o  = saddr_q;
  assign lb_wdata_o = data_q;
  assign sb_wdata_o = data_q;

  assign bus_ack   = lb_phase ? lb_ack_i : (sb_req_o && sb_ack_i);
  assign bus_err   = lb_phase ? lb_err_i : (sb_req_o && sb_err_i);
  assign err_cause = lb_phase ? STOP_LERR : STOP_SERR;

  assign laddr_o = laddr_q;
  assign saddr_o = saddr_q;
  assign count_o = count_q;
  assign cmd_o   = cmd_q;
  assign busy_o  = (state_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sb_hold_q <= 1'b0;
    else         sb_hold_q <= sb_req_o && !sb_ack_i && !sb_err_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      laddr_q      <= '0;
      saddr_q      <= '0;
      ptr_q        <= '0;
      next_q       <= '0;
      count_q      <= '0;
      data_q       <= '0;
      cmd_q        <= '0;
      widx_q       <= '0;
      chain_q      <= 1'b0;
      stop_o       <= 1'b0;
      stop_cause_o <= STOP_DONE;
      cmd_irq_o    <= 1'b0;
    end else begin
      stop_o    <= 1'b0;
      cmd_irq_o <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (cfg_we_i) begin
            unique case (cfg_sel_i)
              REG_CMD:   cmd_q   <= cfg_wdata_i[1:0];
              REG_LADDR: laddr_q <= AW'(cfg_wdata_i);
              REG_SADDR: saddr_q <= AW'(cfg_wdata_i);
              REG_COUNT: count_q <= cfg_wdata_i;
              default: ;
            endcase
          end
          if (start_i) begin
            chain_q <= chain_i;
            if (chain_i) begin
              ptr_q   <= table_i & A_ALIGN;
              widx_q  <= '0;
              state_q <= S_FETCH;
            end else begin
              state_q <= S_CHECK;
            end
          end
        end
        S_FETCH: begin
          if (lb_err_i) begin
            state_q <= S_IDLE; stop_o <= 1'b1; stop_cause_o <= STOP_LERR;
          end else if (lb_ack_i) begin
            unique case (widx_q)
              WIW'(0): laddr_q <= AW'(lb_rdata_i);
              WIW'(1): saddr_q <= AW'(lb_rdata_i);
              WIW'(2): count_q <= lb_rdata_i;
              WIW'(3): cmd_q   <= lb_rdata_i[1:0];
              default: next_q  <= AW'(lb_rdata_i);
            endcase
            if (widx_q == W_LAST) state_q <= S_CHECK;
            else                  widx_q  <= widx_q + WIW'(1);
          end
        end
        S_CHECK: begin
          if (count_q[1:0] != 2'b00) begin
            state_q <= S_IDLE; stop_o <= 1'b1; stop_cause_o <= STOP_FMT;
          end else if (count_q == '0) begin
            if (chain_q && !next_q[0]) begin
              cmd_irq_o <= cmd_q[1];
              ptr_q     <= next_q & A_ALIGN;
              widx_q    <= '0;
              state_q   <= S_FETCH;
            end else begin
              state_q <= S_IDLE; stop_o <= 1'b1; stop_cause_o <= STOP_DONE;
            end
          end else begin
            state_q <= S_RD;
          end
        end
        S_RD: begin
          if (bus_err) begin
            state_q <= S_IDLE; stop_o <= 1'b1; stop_cause_o <= err_cause;
          end else if (bus_ack) begin
            data_q  <= src_local ? lb_rdata_i : sb_rdata_i;
            state_q <= S_WR;
          end
        end
        S_WR: begin
          if (bus_err) begin
            state_q <= S_IDLE; stop_o <= 1'b1; stop_cause_o <= err_cause;
          end else if (bus_ack) begin
            laddr_q <= laddr_q + A_STEP;
            saddr_q <= saddr_q + A_STEP;
            count_q <= count_q - C_STEP;
            state_q <= S_CHECK;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_dma.sv
`timescale 1ns/1ps
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          lb_req_o,
  output logic          lb_we_o,
  output logic [AW-1:0] lb_addr_o,
  output logic [DW-1:0] lb_wdata_o,
  input  logic [DW-1:0] lb_rdata_i,
  input  logic          lb_ack_i,
  input  logic          lb_err_i,
  output logic          sb_req_o,
  output logic          sb_we_o,
  output logic [AW-1:0] sb_addr_o,
  output logic [DW-1:0] sb_wdata_o,
  input  logic [DW-1:0] sb_rdata_i,
  input  logic          sb_ack_i,
  input  logic          sb_err_i,
  output logic          irq_o
);
  logic [AW-1:0]   table_q;
  logic [2*TW-1:0] thr_q;
  logic            chain_q;
  logic            st_done_q, st_lerr_q, st_serr_q, st_fmt_q;

  logic [AW-1:0] eng_laddr, eng_saddr;
  logic [DW-1:0] eng_count;
  logic [1:0]    eng_cmd;
  logic          eng_busy, eng_stop, eng_cmd_irq, sb_allow;
  stop_e         eng_cause;
  logic          start, cfg_we, st_clr;

  assign start  = reg_wr_i && reg_addr_i == REG_CTRL && reg_wdata_i[0] && !eng_busy;
  assign cfg_we = reg_wr_i && !eng_busy;
  assign st_clr = reg_wr_i && reg_addr_i == REG_STATUS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      table_q <= '0;
      thr_q   <= '0;
      chain_q <= 1'b0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == REG_TABLE && !eng_busy) table_q <= AW'(reg_wdata_i);
      if (reg_addr_i == REG_THR) thr_q <= reg_wdata_i[2*TW-1:0];
      if (start) chain_q <= reg_wdata_i[1];
    end
  end

  // sticky status: set on stop wins over same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_done_q <= 1'b0;
      st_lerr_q <= 1'b0;
      st_serr_q <= 1'b0;
      st_fmt_q  <= 1'b0;
    end else begin
      st_done_q <= (st_done_q && !(st_clr && reg_wdata_i[0])) || (eng_stop && eng_cause == STOP_DONE);
      st_lerr_q <= (st_lerr_q && !(st_clr && reg_wdata_i[1])) || (eng_stop && eng_cause == STOP_LERR);
      st_serr_q <= (st_serr_q && !(st_clr && reg_wdata_i[2])) || (eng_stop && eng_cause == STOP_SERR);
      st_fmt_q  <= (st_fmt_q  && !(st_clr && reg_wdata_i[3])) || (eng_stop && eng_cause == STOP_FMT);
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      REG_CTRL:   reg_rdata_o = DW'({chain_q, eng_busy});
      REG_CMD:    reg_rdata_o = DW'(eng_cmd);
      REG_LADDR:  reg_rdata_o = DW'(eng_laddr);
      REG_SADDR:  reg_rdata_o = DW'(eng_saddr);
      REG_COUNT:  reg_rdata_o = eng_count;
      REG_TABLE:  reg_rdata_o = DW'(table_q);
      REG_STATUS: reg_rdata_o = DW'({eng_busy, st_fmt_q, st_serr_q, st_lerr_q, st_done_q});
      default:    reg_rdata_o = DW'(thr_q);
    endcase
  end

  assign irq_o = eng_stop || eng_cmd_irq;

  chain_dma_throttle #(.TW(TW)) u_thr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .on_t_i   (thr_q[TW-1:0]),
    .off_t_i  (thr_q[2*TW-1:TW]),
    .active_i (sb_req_o),
    .allow_o  (sb_allow)
  );

  chain_dma_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .chain_i      (reg_wdata_i[1]),
    .table_i      (table_q),
    .cfg_we_i     (cfg_we),
    .cfg_sel_i    (reg_addr_i),
    .cfg_wdata_i  (reg_wdata_i),
    .laddr_o      (eng_laddr),
    .saddr_o      (eng_saddr),
    .count_o      (eng_count),
    .cmd_o        (eng_cmd),
    .busy_o       (eng_busy),
    .stop_o       (eng_stop),
    .stop_cause_o (eng_cause),
    .cmd_irq_o    (eng_cmd_irq),
    .lb_req_o     (lb_req_o),
    .lb_we_o      (lb_we_o),
    .lb_addr_o    (lb_addr_o),
    .lb_wdata_o   (lb_wdata_o),
    .lb_rdata_i   (lb_rdata_i),
    .lb_ack_i     (lb_ack_i),
    .lb_err_i     (lb_err_i),
    .sb_req_o     (sb_req_o),
    .sb_we_o      (sb_we_o),
    .sb_addr_o    (sb_addr_o),
    .sb_wdata_o   (sb_wdata_o),
    .sb_rdata_i   (sb_rdata_i),
    .sb_ack_i     (sb_ack_i),
    .sb_err_i     (sb_err_i),
    .sb_allow_i   (sb_allow)
  );
endmodule

// File: rtl/chain_dma_chk.sv
`timescale 1ns/1ps
module chain_dma_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          lb_req_i,
  input logic          lb_we_i,
  input logic [AW-1:0] lb_addr_i,
  input logic          lb_ack_i,
  input logic          lb_err_i,
  input logic          sb_req_i,
  input logic          sb_we_i,
  input logic [AW-1:0] sb_addr_i,
  input logic          sb_ack_i,
  input logic          sb_err_i,
  input logic [DW-1:0] count_i,
  input logic          busy_i,
  input logic          irq_i
);
  p_one_bus_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lb_req_i && sb_req_i));

  p_lb_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lb_req_i && !lb_ack_i && !lb_err_i) |=> (lb_req_i && $stable(lb_addr_i)));

  p_sb_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sb_req_i && !sb_ack_i && !sb_err_i) |=> (sb_req_i && $stable(sb_addr_i)));

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lb_req_i && lb_we_i && lb_ack_i) || (sb_req_i && sb_we_i && sb_ack_i))
    |=> (count_i == $past(count_i) - DW'(4)));

  p_stop_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> irq_i);
endmodule

bind chain_dma chain_dma_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .lb_req_i  (lb_req_o),
  .lb_we_i   (lb_we_o),
  .lb_addr_i (lb_addr_o),
  .lb_ack_i  (lb_ack_i),
  .lb_err_i  (lb_err_i),
  .sb_req_i  (sb_req_o),
  .sb_we_i   (sb_we_o),
  .sb_addr_i (sb_addr_o),
  .sb_ack_i  (sb_ack_i),
  .sb_err_i  (sb_err_i),
  .count_i   (eng_count),
  .busy_i    (eng_busy),
  .irq_i     (irq_o)
);

// File: tb/chain_dma_tb_top.sv
`timescale 1ns/1ps
module chain_dma_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lb_req, lb_we, lb_ack, lb_err;
  logic [31:0] lb_addr, lb_wdata, lb_rdata;
  logic        sb_req, sb_we, sb_ack, sb_err;
  logic [31:0] sb_addr, sb_wdata, sb_rdata;
  logic        irq;

  always #5 clk_i = ~clk_i;

  chain_dma dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .lb_req_o(lb_req), .lb_we_o(lb_we), .lb_addr_o(lb_addr), .lb_wdata_o(lb_wdata),
    .lb_rdata_i(lb_rdata), .lb_ack_i(lb_ack), .lb_err_i(lb_err),
    .sb_req_o(sb_req), .sb_we_o(sb_we), .sb_addr_o(sb_addr), .sb_wdata_o(sb_wdata),
    .sb_rdata_i(sb_rdata), .sb_ack_i(sb_ack), .sb_err_i(sb_err),
    .irq_o(irq)
  );

  logic [31:0] lmem [256];
  logic [31:0] smem [256];
  int n_checks = 0, n_fail = 0;
  int irq_cnt = 0, req_cnt = 0, max_gap = 0, low_run = 0;
  bit sb_seen = 0, finished = 0;
  bit lb_err_en = 0, sb_err_en = 0;
  logic [31:0] lb_err_addr = '0, sb_err_addr = '0;

  // stimulus vectors: [24] dir (1 local->system), [23:16] local word, [15:8] system word, [7:0] words
  localparam logic [24:0] VEC [4] = '{
    {1'b1, 8'd2,  8'd10, 8'd4},
    {1'b0, 8'd20, 8'd30, 8'd3},
    {1'b1, 8'd60, 8'd70, 8'd1},
    {1'b0, 8'd80, 8'd90, 8'd8}
  };

  // local bus responder
  initial begin
    lb_ack = 0; lb_err = 0; lb_rdata = '0;
    forever begin
      @(negedge clk_i);
      if (lb_ack || lb_err) begin
        lb_ack = 0; lb_err = 0;
      end else if (lb_req) begin
        if (lb_err_en && lb_addr == lb_err_addr) lb_err = 1;
        else begin
          lb_ack = 1;
          if (lb_we) lmem[lb_addr[9:2]] = lb_wdata;
          lb_rdata = lmem[lb_addr[9:2]];
        end
      end
    end
  end

  // system bus responder
  initial begin
    sb_ack = 0; sb_err = 0; sb_rdata = '0;
    forever begin
      @(negedge clk_i);
      if (sb_ack || sb_err) begin
        sb_ack = 0; sb_err = 0;
      end else if (sb_req) begin
        if (sb_err_en && sb_addr == sb_err_addr) sb_err = 1;
        else begin
          sb_ack = 1;
          if (sb_we) smem[sb_addr[9:2]] = sb_wdata;
          sb_rdata = smem[sb_addr[9:2]];
        end
      end
    end
  end

  // monitors
  initial begin
    forever begin
      @(negedge clk_i);
      if (irq) irq_cnt++;
      if (lb_req || sb_req) req_cnt++;
      if (sb_req) begin
        if (sb_seen && low_run > max_gap) max_gap = low_run;
        low_run = 0;
        sb_seen = 1;
      end else low_run++;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk_i);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    bit idle = 0;
    for (int i = 0; i < 5000 && !idle; i++) begin
      @(negedge clk_i);
      reg_addr = 3'd6;
      #1 idle = !reg_rdata[4];
    end
    if (!idle) chk(32'd0, 32'd1, "watchdog engine idle");
    repeat (2) @(negedge clk_i);
  endtask

  task automatic mem_init();
    for (int i = 0; i < 256; i++) begin
      lmem[i] = 32'hA000_0000 | i;
      smem[i] = 32'h5000_0000 | i;
    end
  endtask

  task automatic clear_mon();
    irq_cnt = 0; req_cnt = 0; max_gap = 0; low_run = 0; sb_seen = 0;
  endtask

  task automatic run_direct(input logic dir, input int lw, input int sw, input int nb);
    reg_write(3'd6, 32'h1F);
    reg_write(3'd1, {31'd0, dir});
    reg_write(3'd2, lw * 4);
    reg_write(3'd3, sw * 4);
    reg_write(3'd4, nb);
    clear_mon();
    reg_write(3'd0, 32'h1);
  endtask

  initial begin
    logic [31:0] rd;
    int gap_free;
    mem_init();
    repeat (3) @(negedge clk_i);
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      reg_read(a[2:0], rd);
      chk(rd, 32'd0, $sformatf("R1 reset reg %0d", a));
    end
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    chk({30'd0, lb_req, sb_req}, 32'd0, "R1 no request after reset");
    chk({31'd0, irq}, 32'd0, "R1 irq low after reset");
    reg_read(3'd6, rd);
    chk(rd, 32'd0, "R1 status after release");

    // R2/R3 vector walk
    gap_free = 0;
    for (int v = 0; v < 4; v++) begin
      logic dir;
      int lw, sw, n;
      dir = VEC[v][24]; lw = VEC[v][23:16]; sw = VEC[v][15:8]; n = VEC[v][7:0];
      mem_init();
      run_direct(dir, lw, sw, n * 4);
      wait_idle();
      if (max_gap > gap_free) gap_free = max_gap;
      for (int i = 0; i < n; i++) begin
        if (dir) chk(smem[sw + i], 32'hA000_0000 | (lw + i), $sformatf("R2 vec%0d word%0d", v, i));
        else     chk(lmem[lw + i], 32'h5000_0000 | (sw + i), $sformatf("R3 vec%0d word%0d", v, i));
      end
      if (dir) chk(smem[sw + n], 32'h5000_0000 | (sw + n), "R2 word past end untouched");
      else     chk(lmem[lw + n], 32'hA000_0000 | (lw + n), "R3 word past end untouched");
      reg_read(3'd2, rd); chk(rd, (lw + n) * 4, "R2 local address advanced");
      reg_read(3'd3, rd); chk(rd, (sw + n) * 4, "R3 system address advanced");
      reg_read(3'd4, rd); chk(rd, 32'd0, "R2 count at zero");
      reg_read(3'd6, rd); chk(rd, 32'h1, "R4 done set, busy clear");
      reg_read(3'd0, rd); chk(rd & 32'h1, 32'd0, "R4 go self-cleared");
      chk(irq_cnt, 32'd1, "R4 single irq pulse");
    end
    chk({31'd0, gap_free >= 10}, 32'd0, "R11 on time 0 leaves bus unthrottled");

    // R5: write 0 keeps, write 1 clears
    reg_write(3'd6, 32'h0);
    reg_read(3'd6, rd); chk(rd, 32'h1, "R5 write 0 keeps done");
    reg_write(3'd6, 32'h1);
    reg_read(3'd6, rd); chk(rd, 32'h0, "R5 write 1 clears done");

    // R13: zero count
    mem_init();
    run_direct(1'b1, 4, 4, 0);
    wait_idle();
    reg_read(3'd6, rd); chk(rd, 32'h1, "R13 zero count done");
    chk(req_cnt, 32'd0, "R13 no bus request");

    // R6: misaligned count
    run_direct(1'b1, 4, 4, 6);
    wait_idle();
    reg_read(3'd6, rd); chk(rd, 32'h8, "R6 format error bit");
    chk(req_cnt, 32'd0, "R6 no bus request");
    chk(irq_cnt, 32'd1, "R6 irq on stop");

    // R7: local bus error on third read
    mem_init();
    lb_err_en = 1; lb_err_addr = 18 * 4;
    run_direct(1'b1, 16, 30, 16);
    wait_idle();
    lb_err_en = 0;
    reg_read(3'd6, rd); chk(rd, 32'h2, "R7 local error bit");
    reg_read(3'd2, rd); chk(rd, 32'h48, "R7 local address at failing beat");
    reg_read(3'd3, rd); chk(rd, 32'h80, "R7 system address at failing beat");
    reg_read(3'd4, rd); chk(rd, 32'd8, "R7 count at failing beat");
    chk(smem[31], 32'hA000_0011, "R7 beat before error done");
    chk(smem[32], 32'h5000_0020, "R7 failing beat not written");

    // R8: system bus error on second write
    mem_init();
    sb_err_en = 1; sb_err_addr = 31 * 4;
    run_direct(1'b1, 16, 30, 16);
    wait_idle();
    sb_err_en = 0;
    reg_read(3'd6, rd); chk(rd, 32'h4, "R8 system error bit");
    reg_read(3'd2, rd); chk(rd, 32'h44, "R8 local address at failing beat");
    reg_read(3'd3, rd); chk(rd, 32'h7C, "R8 system address at failing beat");
    reg_read(3'd4, rd); chk(rd, 32'd12, "R8 count at failing beat");
    chk(smem[30], 32'hA000_0010, "R8 first beat done");
    reg_write(3'd6, 32'h4);
    reg_read(3'd6, rd); chk(rd, 32'h0, "R5 error bit cleared");

    // R9/R10: three-descriptor chain
    mem_init();
    lmem[100] = 32'h0;   lmem[101] = 128 * 4; lmem[102] = 8;  lmem[103] = 32'h3; lmem[104] = 105 * 4;
    lmem[105] = 40 * 4;  lmem[106] = 140 * 4; lmem[107] = 12; lmem[108] = 32'h0; lmem[109] = 110 * 4;
    lmem[110] = 50 * 4;  lmem[111] = 150 * 4; lmem[112] = 4;  lmem[113] = 32'h1; lmem[114] = 32'h1;
    reg_write(3'd6, 32'h1F);
    reg_write(3'd5, 100 * 4);
    reg_read(3'd5, rd); chk(rd, 32'h190, "R9 table readback");
    clear_mon();
    reg_write(3'd0, 32'h3);
    wait_idle();
    chk(smem[128], 32'hA000_0000, "R9 desc0 word0");
    chk(smem[129], 32'hA000_0001, "R9 desc0 word1");
    chk(lmem[40], 32'h5000_008C, "R9 desc1 word0");
    chk(lmem[42], 32'h5000_008E, "R9 desc1 word2");
    chk(smem[150], 32'hA000_0032, "R9 desc2 word0");
    chk(smem[151], 32'h5000_0097, "R9 desc2 past end untouched");
    reg_read(3'd2, rd); chk(rd, 32'hCC, "R9 last local address");
    reg_read(3'd1, rd); chk(rd, 32'h1, "R9 command from last descriptor");
    reg_read(3'd6, rd); chk(rd, 32'h1, "R9 chain done");
    chk(irq_cnt, 32'd2, "R10 one descriptor irq plus stop irq");

    // R11: throttle on 2, off 10
    mem_init();
    reg_write(3'd7, 32'h000A_0002);
    run_direct(1'b1, 0, 40, 24);
    reg_read(3'd6, rd); chk(rd & 32'h10, 32'h10, "R4 busy while running");
    wait_idle();
    chk({31'd0, max_gap >= 10}, 32'd1, "R11 off window respected");
    for (int i = 0; i < 6; i++)
      chk(smem[40 + i], 32'hA000_0000 | i, $sformatf("R11 throttled word%0d", i));
    reg_write(3'd7, 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule